// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the 64-bit byte address for one memory operand of a load/store pipeline. A 3-bit mode chooses the form. The plain forms are base only, base plus displacement, base plus scaled index, and base plus scaled index plus displacement. The unit also computes addresses relative to the following instruction, and the implicit stack accesses of push and pop. All sums wrap modulo 2^64. The displacement arrives on a 32-bit field with a width tag, and only the tagged low bits are sign-extended. The index is scaled by a left shift of 0 to 3 places.

One request is taken whenever `in_valid` is high, and the result appears on the registered outputs one cycle later. Alongside the address, the unit reports whether the address is misaligned for the requested access size. For stack modes it also returns the new stack pointer and a write-back strobe. The unit never touches memory. The misaligned flag is advisory only and never alters the address.

Top module: `agu_top`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, every output register becomes zero, including `out_valid`, `ea`, `misaligned`, `sp_out` and `sp_we`.
- R2: `out_valid` equals `in_valid` from the previous edge. A cycle with `in_valid` low leaves `ea`, `misaligned`, `sp_out` and `sp_we` unchanged.
- R3: With mode 0, EA = base. With mode 1, EA = base + disp. Mode 7 behaves as mode 0.
- R4: With mode 2, EA = base + (index << scale). With mode 3, EA = base + (index << scale) + disp. Here `scale` is 0..3, giving ×1/×2/×4/×8. When `no_index` is 1, the index term is zero.
- R5: The width tag `disp_sel` selects how the displacement is read. Tag 0 takes `disp[7:0]`, tag 1 takes `disp[15:0]`, and tags 2 and 3 take `disp[31:0]`. The selected field is sign-extended to 64 bits, and the bits above it are ignored.
- R6: With mode 4, EA = ip + ilen + disp. For example, ip 0x610, ilen 2 and an 8-bit disp of 0x06 give 0x618.
- R7: With mode 5 (push), EA = sp_in − 8, `sp_out` = sp_in − 8, and `sp_we` = 1.
- R8: With mode 6 (pop), EA = sp_in, `sp_out` = sp_in + 8, and `sp_we` = 1.
- R9: In every mode other than 5 and 6, `sp_out` = sp_in and `sp_we` = 0.
- R10: `size_code` gives the access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. `misaligned` is 1 exactly when the low `size_code` bits of EA are not all zero.
- R11: All address sums wrap modulo 2^64. For example, base 0xFFFF_FFFF_FFFF_FFFF plus disp 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing form (0..7, see R3–R8) |
| base | input | 64 | Base register value |
| index | input | 64 | Index register value |
| no_index | input | 1 | Forces the index term to zero |
| scale | input | 2 | Index shift amount |
| disp | input | 32 | Raw displacement field |
| disp_sel | input | 2 | Displacement width tag |
| ip | input | 64 | Address of current instruction |
| ilen | input | 4 | Length of current instruction in bytes |
| sp_in | input | 64 | Current stack pointer |
| size_code | input | 2 | Access size code |
| out_valid | output | 1 | Result valid |
| ea | output | 64 | Effective address |
| misaligned | output | 1 | EA not aligned to access size |
| sp_out | output | 64 | Stack pointer after the operation |
| sp_we | output | 1 | Stack pointer write-back strobe |

## Verification
The hardest cases to reach are wrap-around sums. Random 64-bit operands almost never land a carry exactly at the top bit in a way that would expose a narrowed adder. The same holds for narrow displacements whose upper raw bits disagree with their sign bit. The stimulus therefore directs corner cases: all-ones bases with small positive displacements, a zero stack pointer on push, and 8-bit negative displacements carried on a raw field full of unrelated upper bits. Random requests cover the rest, with their ranges biased so that alignment flags and every mode appear often.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_REG   = 3'd0,
    AM_DISP  = 3'd1,
    AM_IDX   = 3'd2,
    AM_FULL  = 3'd3,
    AM_IPREL = 3'd4,
    AM_PUSH  = 3'd5,
    AM_POP   = 3'd6,
    AM_RSVD  = 3'd7
  } am_e;

  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DISP_W = 32;

  // Sign-extend the field chosen by the width tag.
  function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d,
                                                  input logic [1:0] sel);
    case (sel)
      2'd0:    return {{(ADDR_W-8){d[7]}}, d[7:0]};
      2'd1:    return {{(ADDR_W-16){d[15]}}, d[15:0]};
      default: return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endcase
  endfunction

  // Index scaled by shift; a suppressed index contributes nothing.
  function automatic logic [ADDR_W-1:0] scaled_index(input logic [ADDR_W-1:0] idx,
                                                     input logic [1:0] sc,
                                                     input logic none);
    return none ? '0 : (idx << sc);
  endfunction

  // Mask of address bits that must be zero for a given size code.
  function automatic logic [ADDR_W-1:0] align_mask(input logic [1:0] sz);
    return (ADDR_W'(1) << sz) - ADDR_W'(1);
  endfunction
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
  import agu_pkg::*;
(
  input  logic [DISP_W-1:0] disp_raw,
  input  logic [1:0]        width_sel,
  output logic [ADDR_W-1:0] disp_ext
);
  always_comb disp_ext = sext_disp(disp_raw, width_sel);
endmodule

// File: rtl/agu_ea_core.sv
module agu_ea_core
  import agu_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned SLOT_SIZE = 8
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic              no_index,
  input  logic [1:0]        scale,
  input  logic [ADDR_W-1:0] disp_ext,
  input  logic [ADDR_W-1:0] ip,
  input  logic [LEN_W-1:0]  ilen,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] sp_nxt,
  output logic              sp_wr
);
  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_SIZE);

  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] next_ip;
  logic [ADDR_W-1:0] sp_dec;
  logic [ADDR_W-1:0] sp_inc;

  always_comb begin
    idx_term = scaled_index(index, scale, no_index);
    next_ip  = ip + ADDR_W'(ilen);
    sp_dec   = sp_in - SLOT;
    sp_inc   = sp_in + SLOT;
  end

  always_comb begin
    ea     = base;
    sp_nxt = sp_in;
    sp_wr  = 1'b0;
    case (am_e'(mode))
      AM_DISP:  ea = base + disp_ext;
      AM_IDX:   ea = base + idx_term;
      AM_FULL:  ea = base + idx_term + disp_ext;
      AM_IPREL: ea = next_ip + disp_ext;
      AM_PUSH: begin
        ea     = sp_dec;
        sp_nxt = sp_dec;
        sp_wr  = 1'b1;
      end
      AM_POP: begin
        ea     = sp_in;
        sp_nxt = sp_inc;
        sp_wr  = 1'b1;
      end
      default:  ea = base;
    endcase
  end
endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk
  import agu_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_code,
  output logic              misaligned
);
  always_comb misaligned = |(addr & align_mask(size_code));
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned SLOT_SIZE = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          mode,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   index,
  input  logic                no_index,
  input  logic [1:0]          scale,
  input  logic [DISP_W-1:0]   disp,
  input  logic [1:0]          disp_sel,
  input  logic [ADDR_W-1:0]   ip,
  input  logic [LEN_W-1:0]    ilen,
  input  logic [ADDR_W-1:0]   sp_in,
  input  logic [1:0]          size_code,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   ea,
  output logic                misaligned,
  output logic [ADDR_W-1:0]   sp_out,
  output logic                sp_we
);
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] ea_next;
  logic [ADDR_W-1:0] sp_next;
  logic              we_next;
  logic              mis_next;

  agu_disp_ext u_disp (
    .disp_raw (disp),
    .width_sel(disp_sel),
    .disp_ext (disp_ext)
  );

  agu_ea_core #(.LEN_W(LEN_W), .SLOT_SIZE(SLOT_SIZE)) u_core (
    .mode    (mode),
    .base    (base),
    .index   (index),
    .no_index(no_index),
    .scale   (scale),
    .disp_ext(disp_ext),
    .ip      (ip),
    .ilen    (ilen),
    .sp_in   (sp_in),
    .ea      (ea_next),
    .sp_nxt  (sp_next),
    .sp_wr   (we_next)
  );

  agu_align_chk u_align (
    .addr      (ea_next),
    .size_code (size_code),
    .misaligned(mis_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      ea         <= '0;
      misaligned <= 1'b0;
      sp_out     <= '0;
      sp_we      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea         <= ea_next;
        misaligned <= mis_next;
        sp_out     <= sp_next;
        sp_we      <= we_next;
      end
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk
  import agu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] sp_in,
  input logic [1:0]        size_code,
  input logic              out_valid,
  input logic [ADDR_W-1:0] ea,
  input logic              misaligned,
  input logic [ADDR_W-1:0] sp_out,
  input logic              sp_we
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                           // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                         // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ea) && $stable(sp_out) && $stable(sp_we)));  // R2
  AST_PUSH_SLOT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd5) |=> (sp_we && ea == sp_out && sp_out == $past(sp_in) - 64'd8)); // R7
  AST_POP_SLOT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd6) |=> (sp_we && ea == $past(sp_in) && sp_out == ea + 64'd8)); // R8
  AST_SP_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode != 3'd5 && mode != 3'd6) |=> (!sp_we && sp_out == $past(sp_in))); // R9
  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd0) |=> !misaligned);                  // R10
endmodule

bind agu_top agu_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .sp_in     (sp_in),
  .size_code (size_code),
  .out_valid (out_valid),
  .ea        (ea),
  .misaligned(misaligned),
  .sp_out    (sp_out),
  .sp_we     (sp_we)
);

// File: tb/tb_agu_top.sv
module tb_agu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [63:0] base = '0, index = '0, ip = '0, sp_in = '0;
  logic        no_index = 1'b0;
  logic [1:0]  scale = '0, disp_sel = '0, size_code = '0;
  logic [31:0] disp = '0;
  logic [3:0]  ilen = '0;
  logic        out_valid, misaligned, sp_we;
  logic [63:0] ea, sp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  agu_top dut (.*);

  function automatic logic [63:0] x_disp(input logic [31:0] d, input logic [1:0] t);
    if (t == 2'd0) return 64'($signed(d[7:0]));
    if (t == 2'd1) return 64'($signed(d[15:0]));
    return 64'($signed(d));
  endfunction

  function automatic logic [63:0] x_ea();
    logic [63:0] ix;
    ix = no_index ? 64'd0 : index * (64'd1 << scale);
    case (mode)
      3'd1: return base + x_disp(disp, disp_sel);
      3'd2: return base + ix;
      3'd3: return base + ix + x_disp(disp, disp_sel);
      3'd4: return ip + {60'd0, ilen} + x_disp(disp, disp_sel);
      3'd5: return sp_in - 64'd8;
      3'd6: return sp_in;
      default: return base;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd1, 3'd0, 3'd7: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge, check the registered result one cycle later.
  task automatic run_op(input string tag);
    logic [63:0] e_ea, e_sp;
    logic e_we, e_mis;
    in_valid = 1'b1;
    e_ea  = x_ea();
    e_we  = (mode == 3'd5) || (mode == 3'd6);
    e_sp  = (mode == 3'd5) ? sp_in - 64'd8 : (mode == 3'd6) ? sp_in + 64'd8 : sp_in;
    e_mis = (e_ea % (64'd1 << size_code)) != 0;
    @(negedge clk);
    chk({tag, " ea"}, ea, e_ea);
    chk("R2 out_valid", {63'd0, out_valid}, 64'd1);
    chk(e_we ? {mode_tag(mode), " sp_out"} : "R9 sp_out", sp_out, e_sp);
    chk(e_we ? {mode_tag(mode), " sp_we"} : "R9 sp_we", {63'd0, sp_we}, {63'd0, e_we});
    chk("R10 misaligned", {63'd0, misaligned}, {63'd0, e_mis});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd7031));
    repeat (3) @(negedge clk);
    chk("R1 ea", ea, 64'd0);
    chk("R1 sp_out", sp_out, 64'd0);
    chk("R1 flags", {61'd0, out_valid, misaligned, sp_we}, 64'd0);
    rst = 1'b0;

    // R6: short jump
    mode = 3'd4; ip = 64'h610; ilen = 4'd2; disp = 32'hABCD_EF06; disp_sel = 2'd0; size_code = 2'd0;
    run_op("R6 jump");
    chk("R6 target", ea, 64'h618);
    // R5: negative 8-bit displacement with junk above the field
    mode = 3'd1; base = 64'h1000; disp = 32'h1234_56FC; disp_sel = 2'd0; size_code = 2'd2;
    run_op("R5 disp8");
    chk("R5 minus4", ea, 64'hFFC);
    disp = 32'h7777_FFF8; disp_sel = 2'd1; run_op("R5 disp16");
    disp = 32'hFFFF_FFF8; disp_sel = 2'd3; run_op("R5 disp32 tag3");
    // R11: wrap
    mode = 3'd1; base = '1; disp = 32'd1; disp_sel = 2'd2; run_op("R11 wrap");
    chk("R11 zero", ea, 64'd0);
    mode = 3'd5; sp_in = 64'd0; size_code = 2'd3; run_op("R11 push wrap");
    // R4: no index suppresses term
    mode = 3'd3; base = 64'h2000; index = 64'h55; no_index = 1'b1; scale = 2'd3; disp = 32'h10; disp_sel = 2'd0;
    run_op("R4 no_index");
    chk("R4 suppressed", ea, 64'h2010);
    no_index = 1'b0; run_op("R4 scaled");
    // R7 / R8
    mode = 3'd5; sp_in = 64'h7FF0; run_op("R7 push");
    mode = 3'd6; sp_in = 64'h7FE8; run_op("R8 pop");
    // R3: reserved code behaves as base only
    mode = 3'd7; base = 64'h3003; size_code = 2'd1; run_op("R3 reserved");
    // R10: misaligned 8-byte access
    mode = 3'd0; base = 64'h44; size_code = 2'd3; run_op("R10 mis8");
    // R2: idle cycle holds outputs
    held = ea;
    in_valid = 1'b0; base = 64'hDEAD; mode = 3'd5;
    @(negedge clk);
    chk("R2 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R2 idle ea", ea, held);
    chk("R2 idle sp_we", {63'd0, sp_we}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      mode = 3'($urandom_range(0, 7));
      base = {$urandom(), $urandom()};
      if (i % 4 == 0) base[5:0] = 6'd0;
      index = {$urandom(), $urandom()};
      no_index = ($urandom_range(0, 5) == 0);
      scale = 2'($urandom_range(0, 3));
      disp = $urandom();
      disp_sel = 2'($urandom_range(0, 3));
      ip = {$urandom(), $urandom()};
      ilen = 4'($urandom_range(1, 15));
      sp_in = {$urandom(), $urandom()};
      if (i % 3 == 0) sp_in[3:0] = 4'd0;
      size_code = 2'($urandom_range(0, 3));
      run_op(mode_tag(mode));
    end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule